// File: doc/BRIEF.md
# Program Counter and Interrupt Sequencer

This block keeps the 16-bit instruction address of a small CPU with an 8-bit datapath and decides, one instruction at a time, where the next fetch comes from. On each instruction boundary the address either moves on by one, jumps to a branch target, or moves on by one plus a byte operand taken from the ALU. That last case is a computed skip, and it carries into the upper address byte. The same boundary is where the block enters and leaves interrupt service.

An interrupt is taken on an instruction boundary when the global enable is set and either the external request is high or a software-interrupt instruction is executed with its own enable set. With that enable clear, the software-interrupt instruction behaves like a plain no-op. On entry, the block saves the address the interrupted code would have run next, loads the fetch address from a programmable vector, clears the global enable and raises an in-service flag. The in-service flag picks the interrupt clock-speed setting in place of the normal one. The return instruction reverses these steps. Its save option also lets it reload the vector with the address that follows the return instruction. The core can read the fetch address, the saved return address and the vector one byte at a time. The vector can be written one byte at a time.

Top module: `pc_irq_seq`

## Requirements
- R1: After reset the fetch address, return address and vector are all 0x0000, the global enable is 0 and the in-service flag is 0.
- R2: A cycle with `step` high and no other request moves the fetch address to its present value plus one. In a cycle with `step` low, the fetch address keeps its value.
- R3: A step with `skip` high moves the fetch address to its present value plus one plus the zero-extended `skip_amt`. The sum carries from the low byte into the high byte, so 0x00FE with `skip_amt`=5 gives 0x0104. A `skip_amt` of 0 gives the next instruction.
- R4: A step with `jump` high loads `jump_addr` into the fetch address. A jump takes priority over a skip in the same step.
- R5: A step with the global enable at 1, no return instruction and `irq_req` high enters interrupt service. The return address becomes the address that step would otherwise have loaded, including any jump or skip. The fetch address becomes the vector, the global enable clears and the in-service flag sets. With the global enable at 0, `irq_req` has no effect.
- R6: A step with `swi` high enters interrupt service as in R5, with return address = fetch address + 1, but only when both `swi_en` and the global enable are 1. Otherwise the step only adds one to the fetch address, and the global enable, in-service flag and return address are unchanged.
- R7: A step with `reti` high loads the fetch address from the return address, sets the global enable and clears the in-service flag. This takes priority over any interrupt in the same step, and a request that is still high is taken on the next step.
- R8: A step with `reti` and `reti_save` both high writes fetch address + 1, taken before the return, into the vector. In that cycle the save takes priority over a vector byte write.
- R9: A cycle with `vec_we` high writes `wdata` into the vector's high byte when `vec_hi` is 1, and into its low byte otherwise.
- R10: A cycle with `gie_we` high sets the global enable to `gie_wval`, unless an interrupt entry or a return happens in the same cycle; in that case the entry or the return decides the enable.
- R11: `spd_sel` equals `spd_irq` while the in-service flag is 1, and equals `spd_norm` otherwise.
- R12: `rd_data` is a combinational byte read selected by `rd_sel`: 0 = fetch address low, 1 = fetch address high, 2 = return address low, 3 = return address high, 4 = vector low, 5 = vector high, and any other value reads 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| step | input | 1 | Instruction boundary: the current instruction completes this cycle |
| jump | input | 1 | Current instruction branches to `jump_addr` |
| jump_addr | input | 16 | Branch target |
| skip | input | 1 | Current instruction is a computed skip |
| skip_amt | input | 8 | Number of instructions to skip |
| irq_req | input | 1 | External interrupt request, level |
| swi | input | 1 | Current instruction is a software interrupt |
| swi_en | input | 1 | Software interrupt enable |
| reti | input | 1 | Current instruction is return-from-interrupt |
| reti_save | input | 1 | Save option of the return instruction |
| gie_we | input | 1 | Global enable write strobe |
| gie_wval | input | 1 | Global enable write value |
| vec_we | input | 1 | Vector byte write strobe |
| vec_hi | input | 1 | Vector byte select: 1 = high byte |
| wdata | input | 8 | Vector byte write data |
| rd_sel | input | 3 | Byte read select |
| spd_norm | input | 4 | Normal clock-speed setting |
| spd_irq | input | 4 | Interrupt clock-speed setting |
| pc | output | 16 | Fetch address |
| ret_addr | output | 16 | Saved return address |
| vec | output | 16 | Interrupt vector |
| gie | output | 1 | Global interrupt enable |
| in_service | output | 1 | Interrupt service in progress |
| spd_sel | output | 4 | Active clock-speed setting |
| rd_data | output | 8 | Byte read data |

## Verification
The hardest case to reach from the ports is a return that meets an external request which never dropped. The return has to win that step, and the request has to be taken on the next one. The stimulus holds `irq_req` high all the way through service, issues the return, and then steps again to see the second entry. A second hard case is an entry on a step that also carries a jump. The stimulus loads the vector with non-zero bytes first, so that the return address (the jump target) and the new fetch address (the vector) can both be told apart from values that would come from a wrong source.

// File: rtl/pc_irq_pkg.sv
package pc_irq_pkg;
    localparam int RD_SEL_W = 3;

    typedef enum logic [RD_SEL_W-1:0] {
        RD_PC_LO  = 3'd0,
        RD_PC_HI  = 3'd1,
        RD_RET_LO = 3'd2,
        RD_RET_HI = 3'd3,
        RD_VEC_LO = 3'd4,
        RD_VEC_HI = 3'd5
    } rd_sel_e;
endpackage

// File: rtl/pc_seq_core.sv
module pc_seq_core #(
    parameter int PC_W   = 16,
    parameter int SKIP_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              step,
    input  logic              jump,
    input  logic [PC_W-1:0]   jump_addr,
    input  logic              skip,
    input  logic [SKIP_W-1:0] skip_amt,
    input  logic              take,
    input  logic [PC_W-1:0]   vec,
    input  logic              reti_go,
    input  logic [PC_W-1:0]   ret_addr,
    output logic [PC_W-1:0]   pc,
    output logic [PC_W-1:0]   pc_norm,
    output logic [PC_W-1:0]   pc_inc
);
    typedef struct packed {
        logic [PC_W-1:0] pc;
    } core_st_t;

    core_st_t s_d, s_q;
    logic [PC_W-1:0] skip_ext;
    logic [PC_W-1:0] pc_seq;

    always_comb begin
        skip_ext = skip ? PC_W'(skip_amt) : '0;
        pc_inc   = s_q.pc + PC_W'(1);
        pc_seq   = pc_inc + skip_ext;
        pc_norm  = jump ? jump_addr : pc_seq;
        s_d      = s_q;
        if (step) begin
            if (reti_go)
                s_d.pc = ret_addr;
            else if (take)
                s_d.pc = vec;
            else
                s_d.pc = pc_norm;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            s_q <= '0;
        else
            s_q <= s_d;
    end

    assign pc = s_q.pc;

    AST_STEP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !step |=> $stable(s_q.pc)); // R2
    AST_JUMP_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (step && jump && !take && !reti_go) |=> s_q.pc == $past(jump_addr)); // R4
    AST_ENTRY_VEC: assert property (@(posedge clk) disable iff (!rst_n)
        (step && take && !reti_go) |=> s_q.pc == $past(vec)); // R5
endmodule

// File: rtl/pc_irq_ctrl.sv
module pc_irq_ctrl #(
    parameter int PC_W   = 16,
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              step,
    input  logic              irq_req,
    input  logic              swi,
    input  logic              swi_en,
    input  logic              reti,
    input  logic              reti_save,
    input  logic              gie_we,
    input  logic              gie_wval,
    input  logic              vec_we,
    input  logic              vec_hi,
    input  logic [BYTE_W-1:0] wdata,
    input  logic [PC_W-1:0]   pc_norm,
    input  logic [PC_W-1:0]   pc_inc,
    output logic              take,
    output logic              reti_go,
    output logic              gie,
    output logic              in_service,
    output logic [PC_W-1:0]   ret_addr,
    output logic [PC_W-1:0]   vec
);
    localparam int HI_W = PC_W - BYTE_W;

    typedef struct packed {
        logic            gie;
        logic            ins;
        logic [PC_W-1:0] ret;
        logic [PC_W-1:0] vec;
    } ctrl_st_t;

    ctrl_st_t s_d, s_q;
    logic     swi_hit;

    always_comb begin
        swi_hit = swi && swi_en;
        reti_go = step && reti;
        take    = step && !reti && s_q.gie && (irq_req || swi_hit);
        s_d     = s_q;

        if (gie_we)
            s_d.gie = gie_wval;

        if (vec_we) begin
            if (vec_hi)
                s_d.vec[PC_W-1:BYTE_W] = HI_W'(wdata);
            else
                s_d.vec[BYTE_W-1:0] = wdata;
        end

        if (reti_go) begin
            s_d.gie = 1'b1;
            s_d.ins = 1'b0;
            if (reti_save)
                s_d.vec = pc_inc;
        end else if (take) begin
            s_d.gie = 1'b0;
            s_d.ins = 1'b1;
            s_d.ret = pc_norm;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            s_q <= '0;
        else
            s_q <= s_d;
    end

    assign gie        = s_q.gie;
    assign in_service = s_q.ins;
    assign ret_addr   = s_q.ret;
    assign vec        = s_q.vec;

    AST_ENTRY_STATE: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> (!s_q.gie && s_q.ins)); // R5
    AST_NO_TAKE_GIE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !reti && !s_q.gie) |=> $stable(s_q.ret)); // R5
    AST_RETI_STATE: assert property (@(posedge clk) disable iff (!rst_n)
        reti_go |=> (s_q.gie && !s_q.ins)); // R7
    AST_RETI_SAVE: assert property (@(posedge clk) disable iff (!rst_n)
        (reti_go && reti_save) |=> s_q.vec == $past(pc_inc)); // R8
endmodule

// File: rtl/pc_irq_seq.sv
module pc_irq_seq #(
    parameter int PC_W   = 16,
    parameter int BYTE_W = 8,
    parameter int SPD_W  = 4
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          step,
    input  logic                          jump,
    input  logic [PC_W-1:0]               jump_addr,
    input  logic                          skip,
    input  logic [BYTE_W-1:0]             skip_amt,
    input  logic                          irq_req,
    input  logic                          swi,
    input  logic                          swi_en,
    input  logic                          reti,
    input  logic                          reti_save,
    input  logic                          gie_we,
    input  logic                          gie_wval,
    input  logic                          vec_we,
    input  logic                          vec_hi,
    input  logic [BYTE_W-1:0]             wdata,
    input  logic [pc_irq_pkg::RD_SEL_W-1:0] rd_sel,
    input  logic [SPD_W-1:0]              spd_norm,
    input  logic [SPD_W-1:0]              spd_irq,
    output logic [PC_W-1:0]               pc,
    output logic [PC_W-1:0]               ret_addr,
    output logic [PC_W-1:0]               vec,
    output logic                          gie,
    output logic                          in_service,
    output logic [SPD_W-1:0]              spd_sel,
    output logic [BYTE_W-1:0]             rd_data
);
    import pc_irq_pkg::*;

    localparam int HI_W = PC_W - BYTE_W;

    logic            take, reti_go;
    logic [PC_W-1:0] pc_norm, pc_inc;

    pc_seq_core #(.PC_W(PC_W), .SKIP_W(BYTE_W)) u_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .step      (step),
        .jump      (jump),
        .jump_addr (jump_addr),
        .skip      (skip),
        .skip_amt  (skip_amt),
        .take      (take),
        .vec       (vec),
        .reti_go   (reti_go),
        .ret_addr  (ret_addr),
        .pc        (pc),
        .pc_norm   (pc_norm),
        .pc_inc    (pc_inc)
    );

    pc_irq_ctrl #(.PC_W(PC_W), .BYTE_W(BYTE_W)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .step       (step),
        .irq_req    (irq_req),
        .swi        (swi),
        .swi_en     (swi_en),
        .reti       (reti),
        .reti_save  (reti_save),
        .gie_we     (gie_we),
        .gie_wval   (gie_wval),
        .vec_we     (vec_we),
        .vec_hi     (vec_hi),
        .wdata      (wdata),
        .pc_norm    (pc_norm),
        .pc_inc     (pc_inc),
        .take       (take),
        .reti_go    (reti_go),
        .gie        (gie),
        .in_service (in_service),
        .ret_addr   (ret_addr),
        .vec        (vec)
    );

    always_comb begin
        spd_sel = in_service ? spd_irq : spd_norm;
        case (rd_sel)
            RD_PC_LO:  rd_data = pc[BYTE_W-1:0];
            RD_PC_HI:  rd_data = BYTE_W'(pc[PC_W-1:BYTE_W]);
            RD_RET_LO: rd_data = ret_addr[BYTE_W-1:0];
            RD_RET_HI: rd_data = BYTE_W'(ret_addr[PC_W-1:BYTE_W]);
            RD_VEC_LO: rd_data = vec[BYTE_W-1:0];
            RD_VEC_HI: rd_data = BYTE_W'(vec[PC_W-1:BYTE_W]);
            default:   rd_data = '0;
        endcase
    end

    AST_VEC_BYTE_WR: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_we && vec_hi && !reti_go) |=> vec[PC_W-1:BYTE_W] == HI_W'($past(wdata))); // R9
    AST_GIE_WR: assert property (@(posedge clk) disable iff (!rst_n)
        (gie_we && !take && !reti_go) |=> gie == $past(gie_wval)); // R10
endmodule

// File: tb/tb_pc_irq_seq.sv
module tb_pc_irq_seq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        step = 0, jump = 0, skip = 0, irq_req = 0, swi = 0, swi_en = 0;
    logic        reti = 0, reti_save = 0, gie_we = 0, gie_wval = 0, vec_we = 0, vec_hi = 0;
    logic [15:0] jump_addr = '0;
    logic [7:0]  skip_amt = '0, wdata = '0;
    logic [2:0]  rd_sel = '0;
    logic [3:0]  spd_norm = 4'h3, spd_irq = 4'hA;
    logic [15:0] pc, ret_addr, vec;
    logic        gie, in_service;
    logic [3:0]  spd_sel;
    logic [7:0]  rd_data;

    int checks = 0;
    int failures = 0;

    typedef struct {
        string       tag;
        logic [15:0] pc, ret, vec;
        logic        gie, ins;
        logic [2:0]  sel;
    } exp_t;

    exp_t q[$];

    logic [15:0] m_pc = 0, m_ret = 0, m_vec = 0;
    logic        m_gie = 0, m_ins = 0;

    always #10 clk = ~clk;

    pc_irq_seq dut (
        .clk(clk), .rst_n(rst_n), .step(step), .jump(jump), .jump_addr(jump_addr),
        .skip(skip), .skip_amt(skip_amt), .irq_req(irq_req), .swi(swi), .swi_en(swi_en),
        .reti(reti), .reti_save(reti_save), .gie_we(gie_we), .gie_wval(gie_wval),
        .vec_we(vec_we), .vec_hi(vec_hi), .wdata(wdata), .rd_sel(rd_sel),
        .spd_norm(spd_norm), .spd_irq(spd_irq), .pc(pc), .ret_addr(ret_addr), .vec(vec),
        .gie(gie), .in_service(in_service), .spd_sel(spd_sel), .rd_data(rd_data)
    );

    function automatic logic [7:0] exp_rd(logic [2:0] s, logic [15:0] p, logic [15:0] r, logic [15:0] v);
        case (s)
            3'd0: return p[7:0];
            3'd1: return p[15:8];
            3'd2: return r[7:0];
            3'd3: return r[15:8];
            3'd4: return v[7:0];
            3'd5: return v[15:8];
            default: return 8'h00;
        endcase
    endfunction

    task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // driver: called at a falling edge with inputs set; models one cycle and queues the result
    task automatic apply(string tag);
        exp_t e;
        logic [15:0] nxt;
        logic        tk;
        nxt = jump ? jump_addr : m_pc + 16'd1 + (skip ? {8'd0, skip_amt} : 16'd0);
        tk  = step && !reti && m_gie && (irq_req || (swi && swi_en));
        if (gie_we) m_gie = gie_wval;
        if (vec_we) begin
            if (vec_hi) m_vec[15:8] = wdata; else m_vec[7:0] = wdata;
        end
        if (step && reti) begin
            if (reti_save) m_vec = m_pc + 16'd1;
            m_pc = m_ret; m_gie = 1'b1; m_ins = 1'b0;
        end else if (tk) begin
            m_ret = nxt; m_pc = m_vec; m_gie = 1'b0; m_ins = 1'b1;
        end else if (step) begin
            m_pc = nxt;
        end
        e.tag = tag; e.pc = m_pc; e.ret = m_ret; e.vec = m_vec;
        e.gie = m_gie; e.ins = m_ins; e.sel = rd_sel;
        q.push_back(e);
        @(negedge clk);
        step = 0; jump = 0; skip = 0; swi = 0; reti = 0; reti_save = 0;
        gie_we = 0; vec_we = 0;
    endtask

    // monitor: compares after each rising edge
    initial begin
        forever begin
            exp_t e;
            @(posedge clk);
            #4;
            if (q.size() > 0) begin
                e = q.pop_front();
                check({e.tag, " pc"}, 64'(pc), 64'(e.pc));
                check({e.tag, " ret_addr"}, 64'(ret_addr), 64'(e.ret));
                check({e.tag, " vec"}, 64'(vec), 64'(e.vec));
                check({e.tag, " gie/in_service"}, 64'({gie, in_service}), 64'({e.gie, e.ins}));
                check("R11 spd_sel", 64'(spd_sel), 64'(e.ins ? spd_irq : spd_norm));
                check("R12 rd_data", 64'(rd_data), 64'(exp_rd(e.sel, e.pc, e.ret, e.vec)));
            end
        end
    end

    initial begin
        #(20 * 100000);
        failures++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 reset pc", 64'(pc), 64'h0);
        check("R1 reset ret/vec", 64'({ret_addr, vec}), 64'h0);
        check("R1 reset gie/in_service", 64'({gie, in_service}), 64'h0);

        // R2 plain steps and a hold
        step = 1; apply("R2 step");
        step = 1; apply("R2 step");
        apply("R2 hold");
        step = 1; rd_sel = 3'd0; apply("R2 step read pc lo");

        // R3 computed skips
        step = 1; skip = 1; skip_amt = 8'd1; apply("R3 skip 1");
        step = 1; skip = 1; skip_amt = 8'd2; apply("R3 skip 2");
        step = 1; skip = 1; skip_amt = 8'd0; apply("R3 skip 0");
        step = 1; jump = 1; jump_addr = 16'h00FE; apply("R4 jump to 00FE");
        step = 1; skip = 1; skip_amt = 8'd5; rd_sel = 3'd1; apply("R3 skip carry");

        // R4 jump beats skip
        step = 1; jump = 1; jump_addr = 16'h0400; skip = 1; skip_amt = 8'd9; apply("R4 jump over skip");

        // R9 vector bytes, R12 reads
        vec_we = 1; vec_hi = 0; wdata = 8'h34; rd_sel = 3'd4; apply("R9 vec lo");
        vec_we = 1; vec_hi = 1; wdata = 8'h12; rd_sel = 3'd5; apply("R9 vec hi");

        // R5 request ignored with enable clear
        irq_req = 1; step = 1; apply("R5 irq gie off");
        // R10 enable write
        gie_we = 1; gie_wval = 1; apply("R10 gie set");
        // R5 entry
        step = 1; rd_sel = 3'd2; apply("R5 irq entry");
        step = 1; rd_sel = 3'd3; apply("R5 step in service");
        rd_sel = 3'd6; apply("R12 unmapped select");

        // R7 return wins over a still-high request, then request taken
        step = 1; reti = 1; apply("R7 reti with irq high");
        step = 1; apply("R7 pending irq taken next step");
        // R8 return with save beats a byte write
        irq_req = 0;
        step = 1; reti = 1; reti_save = 1; vec_we = 1; vec_hi = 1; wdata = 8'hEE;
        rd_sel = 3'd5; apply("R8 reti save");

        // R6 software interrupt
        step = 1; swi = 1; swi_en = 0; apply("R6 swi disabled nop");
        step = 1; swi = 1; swi_en = 1; apply("R6 swi entry");
        step = 1; reti = 1; apply("R7 reti from swi");
        gie_we = 1; gie_wval = 0; apply("R10 gie clear");
        step = 1; swi = 1; swi_en = 1; apply("R6 swi gie off nop");

        // R10 write ignored on entry; R5 entry with jump
        gie_we = 1; gie_wval = 1; apply("R10 gie set again");
        irq_req = 1; step = 1; jump = 1; jump_addr = 16'h0ABC; gie_we = 1; gie_wval = 1;
        apply("R5 entry with jump");
        irq_req = 0;
        step = 1; reti = 1; apply("R7 reti to jump target");

        @(negedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule